// File: doc/BRIEF.md
# Page-Table Word Cache

This block sits between a page-table walker and memory. The walker asks for 32-bit directory and table words by physical byte address. The cache either answers from a small direct-mapped store of single-word lines or forwards the read to memory and installs the returned word. Physical addresses are 34 bits wide by default.

Software controls the cache through a write-only register port:
- a configuration word turns caching on, caps the number of memory reads in flight and selects an index hash;
- a high-address register supplies the two upper physical address bits for flushes;
- a flush word either drops every line, or drops only the lines that share one memory atom with a given address.

A flush that lands while a fill is still outstanding stops that fill from being installed. Software is expected to flush everything before it turns translation on.

Top module: `pteWordCache`

## Requirements
- R1: After reset every line is invalid, caching is off, the limit and the index map are 0, the flush high bits are 0, and no response or memory read is presented. The first read after caching is turned on therefore goes to memory.
- R2: While caching is off (config bit 29 = 0), every accepted read is forwarded to memory and no line is filled, even when the same address repeats.
- R3: With caching on, a read whose word is cached is answered with the cached word one cycle after acceptance, and no memory read is issued.
- R4: A read that misses is forwarded with its address word-aligned. Its response carries the memory word in the same cycle the memory returns it. With caching on, that word is installed in its line.
- R5: A write to register 2 with bit 0 = 0 invalidates every line.
- R6: A write to register 2 with bit 0 = 1 forms an address from the written word, aligns it down to the 32-byte atom, and invalidates only the lines whose word lies in that atom.
- R7: Register 1 bits [1:0] supply physical address bits [33:32] of the flush address. They must be written before the flush word, and a flush with the wrong high bits leaves the line cached.
- R8: Register 0 holds enable in bit 29, the limit in bits [27:24] and the index map in bits [5:0]. The line index is w[3:0] ^ (w[7:4] & map[3:0]), where w is the word address (byte address >> 2).
- R9: The number of memory reads in flight never exceeds the limit. A limit of 0 allows up to the 16-entry pending depth.
- R10: A flush that covers a word whose fill is still outstanding prevents that fill from being installed. A flush of another atom does not.
- R11: No read is accepted in a cycle with a register write. A hit is held off while any miss is outstanding.
- R12: Responses return in acceptance order, one per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 config, 1 flush high bits, 2 flush |
| regWdata | input | 32 | Register write data |
| reqValid | input | 1 | Walker read request valid |
| reqReady | output | 1 | Read request accepted this cycle |
| reqAddr | input | 34 | Physical byte address of the word |
| rspValid | output | 1 | Response word valid |
| rspData | output | 32 | Response word |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 34 | Word-aligned memory read address |
| memRspValid | input | 1 | Memory returns a word (in request order) |
| memRspData | input | 32 | Word returned by memory |

## Verification
A hit answers on the clock after the acceptance edge. A miss answers in the very cycle memory returns the word, so its response time is the acceptance cycle plus the memory model's latency. The bench drives inputs on the falling edge. It reads handshakes two time units later and reads responses three units later, so each result is compared in the cycle it is due. Each acceptance and each response is stamped with the bench cycle count, and the latency checks compare those stamps. Hit or miss is judged from the memory model's read count together with memory contents that the bench changes between fills.

// File: rtl/pteCachePkg.sv
package pteCachePkg;
  typedef enum logic [1:0] {
    REG_CFG      = 2'd0,
    REG_FLUSH_HI = 2'd1,
    REG_FLUSH    = 2'd2,
    REG_SPARE    = 2'd3
  } regSelE;

  localparam int CFG_EN_BIT  = 29;
  localparam int CFG_LIM_LSB = 24;
  localparam int LIM_W       = 4;
  localparam int MAP_W       = 6;

  typedef struct packed {
    logic hitTake;
    logic fillEn;
    logic flushAll;
    logic flushAddr;
  } strobeT;
endpackage

// File: rtl/pteCacheStore.sv
module pteCacheStore
  import pteCachePkg::*;
#(
  parameter int TAG_W  = 32,
  parameter int IDX_W  = 4,
  parameter int ATOM_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strobe,
  input  logic [TAG_W-1:0]        lookupTag,
  input  logic [IDX_W-1:0]        idxMap,
  output logic                    lookupHit,
  output logic [IDX_W-1:0]        lookupIdx,
  input  logic [IDX_W-1:0]        fillIdx,
  input  logic [TAG_W-1:0]        fillTag,
  input  logic [DATA_W-1:0]       fillData,
  input  logic [TAG_W-ATOM_W-1:0] flushKey,
  output logic                    hitRspValid,
  output logic [DATA_W-1:0]       hitRspData
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  lineValid;
  logic [LINES-1:0]  clrLine;
  logic [TAG_W-1:0]  lineTag  [LINES];
  logic [DATA_W-1:0] lineData [LINES];

  assign lookupIdx = lookupTag[IDX_W-1:0] ^ (lookupTag[2*IDX_W-1:IDX_W] & idxMap);
  assign lookupHit = lineValid[lookupIdx] && (lineTag[lookupIdx] == lookupTag);

  for (genvar i = 0; i < LINES; i++) begin : gLine
    assign clrLine[i] = strobe.flushAll ||
                        (strobe.flushAddr && (lineTag[i][TAG_W-1:ATOM_W] == flushKey));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strobe.fillEn && (fillIdx == IDX_W'(i))) lineValid[i] <= 1'b1;
        else if (clrLine[i])                           lineValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEn) begin
      lineTag[fillIdx]  <= fillTag;
      lineData[fillIdx] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitRspValid <= 1'b0;
      hitRspData  <= '0;
    end else begin
      hitRspValid <= strobe.hitTake;
      if (strobe.hitTake) hitRspData <= lineData[lookupIdx];
    end
  end

  // R5: a flush-all leaves no valid line behind
  p_flushall_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (lineValid == '0));

  // R4: an installed fill leaves its line valid
  p_fill_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> lineValid[$past(fillIdx)]);
endmodule

// File: rtl/pteCacheCtrl.sv
module pteCacheCtrl
  import pteCachePkg::*;
#(
  parameter int PA_W       = 34,
  parameter int IDX_W      = 4,
  parameter int ATOM_W     = 3,
  parameter int PEND_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [1:0]              regAddr,
  input  logic [31:0]             regWdata,
  input  logic                    reqValid,
  input  logic [PA_W-1:0]         reqAddr,
  output logic                    reqReady,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [PA_W-1:0]         memReqAddr,
  input  logic                    memRspValid,
  input  logic                    lookupHit,
  input  logic [IDX_W-1:0]        lookupIdx,
  output strobeT                  strobe,
  output logic [IDX_W-1:0]        fillIdx,
  output logic [PA_W-3:0]         fillTag,
  output logic [PA_W-3-ATOM_W:0]  flushKey,
  output logic [IDX_W-1:0]        idxMap
);
  localparam int TAG_W = PA_W - 2;
  localparam int KEY_W = TAG_W - ATOM_W;
  localparam int HI_W  = PA_W - 32;
  localparam int PTR_W = $clog2(PEND_DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic             cfgEnable;
  logic [LIM_W-1:0] cfgLimit;
  logic [MAP_W-1:0] cfgMap;
  logic [HI_W-1:0]  flushHi;

  logic [TAG_W-1:0]      pendTag [PEND_DEPTH];
  logic [IDX_W-1:0]      pendIdx [PEND_DEPTH];
  logic [PEND_DEPTH-1:0] pendKeep;
  logic [PTR_W-1:0]      wrPtr, rdPtr;
  logic [CNT_W-1:0]      pendCnt;

  logic            flushWr, isHit, limitOk, hitTake, push, pop, headKill;
  logic [PA_W-1:0] flushByte;
  logic [TAG_W-1:0] reqTag;
  logic            unusedBits;

  assign unusedBits = ^{regWdata[31:30], regWdata[28], regWdata[23:MAP_W],
                        reqAddr[1:0], cfgMap};

  // configuration and flush-high registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      cfgLimit  <= '0;
      cfgMap    <= '0;
      flushHi   <= '0;
    end else if (regWe) begin
      if (regAddr == REG_CFG) begin
        cfgEnable <= regWdata[CFG_EN_BIT];
        cfgLimit  <= regWdata[CFG_LIM_LSB +: LIM_W];
        cfgMap    <= regWdata[MAP_W-1:0];
      end
      if (regAddr == REG_FLUSH_HI) flushHi <= regWdata[HI_W-1:0];
    end
  end

  assign idxMap    = cfgMap[IDX_W-1:0];
  assign flushWr   = regWe && (regAddr == REG_FLUSH);
  assign flushByte = {flushHi, regWdata};
  assign flushKey  = flushByte[PA_W-1 -: KEY_W];

  // request handling
  assign reqTag     = reqAddr[PA_W-1:2];
  assign isHit      = cfgEnable && lookupHit;
  assign limitOk    = (pendCnt < CNT_W'(PEND_DEPTH)) &&
                      ((cfgLimit == '0) || (int'(pendCnt) < int'(cfgLimit)));
  assign memReqValid = reqValid && !regWe && !isHit && limitOk;
  assign memReqAddr  = {reqTag, 2'b00};
  assign reqReady    = !regWe && (isHit ? (pendCnt == '0) : (limitOk && memReqReady));
  assign hitTake     = reqValid && reqReady && isHit;
  assign push        = memReqValid && memReqReady;
  assign pop         = memRspValid && (pendCnt != '0);

  assign headKill = strobe.flushAll ||
                    (strobe.flushAddr && (pendTag[rdPtr][TAG_W-1:ATOM_W] == flushKey));

  assign strobe.hitTake   = hitTake;
  assign strobe.flushAll  = flushWr && !regWdata[0];
  assign strobe.flushAddr = flushWr && regWdata[0];
  assign strobe.fillEn    = pop && pendKeep[rdPtr] && !headKill;
  assign fillIdx          = pendIdx[rdPtr];
  assign fillTag          = pendTag[rdPtr];

  // pending-fill queue
  always_ff @(posedge clk) begin
    if (push) begin
      pendTag[wrPtr] <= reqTag;
      pendIdx[wrPtr] <= lookupIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendKeep <= '0;
    end else begin
      for (int k = 0; k < PEND_DEPTH; k++) begin
        if (push && (wrPtr == PTR_W'(k)))
          pendKeep[k] <= cfgEnable;
        else if (strobe.flushAll ||
                 (strobe.flushAddr && (pendTag[k][TAG_W-1:ATOM_W] == flushKey)))
          pendKeep[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      pendCnt <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // R9: a new memory read only leaves while below the limit
  p_limit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && (cfgLimit != '0)) |-> (int'(pendCnt) < int'(cfgLimit)));

  // R9: pending count stays within the queue depth
  p_depth_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CNT_W'(PEND_DEPTH));

  // R11: no acceptance during a register write
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !reqReady);

  // R2: with caching off an accepted read always goes to memory
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !cfgEnable) |-> memReqValid);

  // R12: memory only answers reads that are outstanding
  p_rsp_pending_r12: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (pendCnt != '0));
endmodule

// File: rtl/pteWordCache.sv
module pteWordCache
  import pteCachePkg::*;
#(
  parameter int PA_W       = 34,
  parameter int IDX_W      = 4,
  parameter int ATOM_BYTES = 32,
  parameter int PEND_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [1:0]      regAddr,
  input  logic [31:0]     regWdata,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [PA_W-1:0] reqAddr,
  output logic            rspValid,
  output logic [31:0]     rspData,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [PA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [31:0]     memRspData
);
  localparam int TAG_W  = PA_W - 2;
  localparam int ATOM_W = $clog2(ATOM_BYTES) - 2;
  localparam int KEY_W  = TAG_W - ATOM_W;

  strobeT            strobe;
  logic              lookupHit;
  logic [IDX_W-1:0]  lookupIdx, fillIdx, idxMap;
  logic [TAG_W-1:0]  fillTag;
  logic [KEY_W-1:0]  flushKey;
  logic              hitRspValid;
  logic [31:0]       hitRspData;

  pteCacheCtrl #(
    .PA_W(PA_W), .IDX_W(IDX_W), .ATOM_W(ATOM_W), .PEND_DEPTH(PEND_DEPTH)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid),
    .lookupHit(lookupHit), .lookupIdx(lookupIdx),
    .strobe(strobe), .fillIdx(fillIdx), .fillTag(fillTag),
    .flushKey(flushKey), .idxMap(idxMap)
  );

  pteCacheStore #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .ATOM_W(ATOM_W), .DATA_W(32)
  ) store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupTag(reqAddr[PA_W-1:2]), .idxMap(idxMap),
    .lookupHit(lookupHit), .lookupIdx(lookupIdx),
    .fillIdx(fillIdx), .fillTag(fillTag), .fillData(memRspData),
    .flushKey(flushKey),
    .hitRspValid(hitRspValid), .hitRspData(hitRspData)
  );

  assign rspValid = hitRspValid || memRspValid;
  assign rspData  = hitRspValid ? hitRspData : memRspData;

  // R12: a hit answer never collides with a memory answer
  p_rsp_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(hitRspValid && memRspValid));
endmodule

// File: tb/pteWordCache_test.sv
module pteWordCache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [33:0] reqAddr = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [33:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  pteWordCache uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycle = 0;
  int memLat = 1, stallPct = 0, memReads = 0, maxOut = 0;
  int lastAccept = 0, lastRsp = 0;
  logic [7:0] gen = 8'd0;
  bit done = 1'b0;
  logic [33:0] memQ[$];
  int memDue[$];
  logic [31:0] expQ[$];
  string tagQ[$];

  function automatic logic [31:0] memWord(logic [33:0] a);
    return a[31:0] ^ 32'hC3A5_0000 ^ {24'h0, gen} ^ {a[33:32], 30'h0};
  endfunction

  function automatic logic [31:0] cfgWord(bit en, int lim, int map);
    return (32'(en) << 29) | ((32'(lim) & 32'hF) << 24) | (32'(map) & 32'h3F);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: in-order, fixed latency, optional ready stalls
  always @(negedge clk) begin
    cycle++;
    if (memQ.size() > 0 && memDue[0] <= cycle) begin
      memRspValid = 1'b1;
      memRspData  = memWord(memQ[0]);
      void'(memQ.pop_front());
      void'(memDue.pop_front());
    end else begin
      memRspValid = 1'b0;
    end
    memReqReady = (int'($urandom % 100) >= stallPct);
    #1;
    if (rstN && memReqValid && memReqReady) begin
      memQ.push_back(memReqAddr);
      memDue.push_back(cycle + memLat);
      memReads++;
      if (memQ.size() > maxOut) maxOut = memQ.size();
    end
  end

  // response monitor (R12 order)
  always @(negedge clk) begin
    #3;
    if (rstN && rspValid) begin
      lastRsp = cycle;
      if (expQ.size() == 0) begin
        chk("R12 unexpected response", 64'(rspData), 64'hDEAD);
      end else begin
        chk(tagQ.pop_front(), 64'(rspData), 64'(expQ.pop_front()));
      end
    end
  end

  task automatic issue(logic [33:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    #2;
    while (!reqReady) begin
      @(negedge clk);
      #2;
    end
    lastAccept = cycle;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || memQ.size() != 0) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    #4;
    chk("drain outstanding", 64'(expQ.size() + memQ.size()), 64'd0);
  endtask

  task automatic rd(logic [33:0] a, string tag);
    issue(a, memWord(a), tag);
    drain();
  endtask

  task automatic wr(logic [1:0] ad, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = ad; regWdata = d;
    @(posedge clk);
    #1 regWe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [33:0] aA, aB, aC, aD, aX, aY, aE, aE2, aF;
    logic [31:0] oldA;
    int m0;
    void'($urandom(32'd20240611));
    aA = 34'h0_0000_1000; aB = 34'h0_0000_1024; aC = 34'h0_0000_101C;
    aD = 34'h1_0000_1000; aX = 34'h0_0000_2000; aY = 34'h0_0000_2040;
    aE = 34'h0_0000_5000; aE2 = 34'h0_0000_6000; aF = 34'h0_0000_6100;

    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #3;
    chk("R1 no response after reset", 64'(rspValid), 64'd0);
    chk("R1 no memory read after reset", 64'(memReqValid), 64'd0);

    // R2: disabled, repeats go to memory
    m0 = memReads;
    rd(aA, "R2 data disabled"); rd(aA, "R2 data disabled again");
    chk("R2 both reads reach memory", 64'(memReads - m0), 64'd2);

    // enable: first read misses (nothing filled while off, R1/R2)
    wr(2'd0, cfgWord(1, 0, 0));
    memLat = 3;
    m0 = memReads;
    rd(aA, "R4 miss data");
    chk("R2 no fill while disabled", 64'(memReads - m0), 64'd1);
    chk("R4 miss response latency", 64'(lastRsp - lastAccept), 64'd3);

    // R3: hit returns old word after memory changed
    oldA = memWord(aA);
    gen = 8'd1;
    m0 = memReads;
    issue(aA, oldA, "R3 hit returns cached word");
    drain();
    chk("R3 no memory read on hit", 64'(memReads - m0), 64'd0);
    chk("R3 hit one cycle after accept", 64'(lastRsp - lastAccept), 64'd1);

    // R5: flush all
    wr(2'd2, 32'h0);
    m0 = memReads;
    rd(aA, "R5 data after flush-all");
    chk("R5 read misses after flush-all", 64'(memReads - m0), 64'd1);

    // R6: flush by address, aligned down to atom
    rd(aB, "R6 fill B"); rd(aC, "R6 fill C");
    wr(2'd2, 32'h0000_1011);
    m0 = memReads;
    rd(aA, "R6 A data"); rd(aC, "R6 C data");
    chk("R6 same-atom lines invalidated", 64'(memReads - m0), 64'd2);
    m0 = memReads;
    rd(aB, "R6 B data");
    chk("R6 other atom kept", 64'(memReads - m0), 64'd0);

    // R7: high address bits
    rd(aD, "R7 fill high address");
    wr(2'd2, 32'h0000_1001);
    m0 = memReads;
    rd(aD, "R7 D data");
    chk("R7 wrong high bits keep line", 64'(memReads - m0), 64'd0);
    wr(2'd1, 32'h1);
    wr(2'd2, 32'h0000_1001);
    m0 = memReads;
    rd(aD, "R7 D data refetch");
    chk("R7 matching high bits flush", 64'(memReads - m0), 64'd1);
    wr(2'd1, 32'h0);

    // R8: index map
    wr(2'd2, 32'h0);
    m0 = memReads;
    rd(aX, "R8 X"); rd(aY, "R8 Y"); rd(aX, "R8 X again");
    chk("R8 map 0 conflict", 64'(memReads - m0), 64'd3);
    wr(2'd0, cfgWord(1, 0, 'hF));
    wr(2'd2, 32'h0);
    m0 = memReads;
    rd(aX, "R8 X"); rd(aY, "R8 Y"); rd(aX, "R8 X hit");
    chk("R8 map F separates lines", 64'(memReads - m0), 64'd2);

    // R9: outstanding limit
    memLat = 12;
    wr(2'd0, cfgWord(1, 2, 'hF));
    wr(2'd2, 32'h0);
    maxOut = 0;
    for (int i = 0; i < 6; i++) issue(34'h3000 + 34'(i * 4), memWord(34'h3000 + 34'(i * 4)), "R9 data limit 2");
    drain();
    chk("R9 at most 2 in flight", 64'(maxOut), 64'd2);
    wr(2'd0, cfgWord(1, 0, 'hF));
    maxOut = 0;
    for (int i = 0; i < 6; i++) issue(34'h3400 + 34'(i * 4), memWord(34'h3400 + 34'(i * 4)), "R9 data no limit");
    drain();
    chk("R9 limit 0 lets 6 fly", 64'(maxOut), 64'd6);

    // R10: flush of a pending fill
    issue(aE, memWord(aE), "R10 pending data");
    wr(2'd2, 32'h0);
    drain();
    m0 = memReads;
    rd(aE, "R10 E refetch");
    chk("R10 killed fill not installed", 64'(memReads - m0), 64'd1);
    issue(aE2, memWord(aE2), "R10 pending data 2");
    wr(2'd2, 32'h0000_7001);
    drain();
    m0 = memReads;
    rd(aE2, "R10 E2 data");
    chk("R10 other-atom flush keeps fill", 64'(memReads - m0), 64'd0);

    // R11: register write blocks acceptance; hit waits behind a miss
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 32'h0;
    reqValid = 1'b1; reqAddr = aE2;
    #2;
    chk("R11 no accept during register write", 64'(reqReady), 64'd0);
    @(posedge clk);
    #1 regWe = 1'b0; reqValid = 1'b0;
    issue(aF, memWord(aF), "R12 miss answered first");
    @(negedge clk);
    reqValid = 1'b1; reqAddr = aE2;
    #2;
    chk("R11 hit held behind miss", 64'(reqReady), 64'd0);
    @(posedge clk);
    #1 reqValid = 1'b0;
    issue(aE2, memWord(aE2), "R12 hit answered second");
    drain();

    // constrained random mix
    stallPct = 25;
    for (int n = 0; n < 500; n++) begin
      int r, k;
      logic [33:0] pa;
      r = int'($urandom % 100);
      k = int'($urandom % 24);
      pa = {1'b0, 1'(k & 1), 32'h8000 + 32'(k >> 1) * 32'h14};
      memLat = 1 + int'($urandom % 4);
      if (r < 78) begin
        issue(pa, memWord(pa), "R4 random data");
      end else if (r < 86) begin
        wr(2'd1, 32'(pa[33:32]));
        wr(2'd2, pa[31:0] | 32'h1);
      end else if (r < 90) begin
        wr(2'd2, 32'h0);
      end else begin
        wr(2'd0, cfgWord(1, int'($urandom % 16), int'($urandom % 64)));
      end
    end
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule